// File: doc/BRIEF.md
# Flash Reset-Pin Sequencer

This block sits beside the embedded program/erase engine of a flash device and decides how the device reacts to its active-low hardware reset pin. It watches the pin on every clock edge. A low level is accepted as a real reset only after it has been held for a minimum number of cycles. When a reset is accepted, the block tells the engine to abandon any program or erase in progress. It floats the data outputs while the pin stays low, and it blocks command decoding until the device can be read again.

The block also drives the ready/busy pin. If the reset arrives while the engine is busy, that pin stays low for a long internal clean-up time. If the reset arrives while the engine is idle, the pin stays high and a shorter internal time applies. Reads become legal again only when two things are true: the internal time has run out, and a separate recovery interval has passed since the pin went back high. At that point the device is back in array-read mode. All times are parameters counted in clock cycles.

Top module: `flash_rst_seq`

## Requirements
- R1: The reset pin is accepted only on the PULSE_MIN-th consecutive clock edge at which it is sampled low. A low run that is shorter changes no output, and a high sample resets the run count.
- R2: On the edge of acceptance, abort_req is high for exactly one cycle if engine_busy was sampled high on that edge. It is never asserted otherwise, including on a re-assertion during recovery.
- R3: out_hiz is high from the edge of acceptance for as long as the pin is sampled low. It clears on the first edge at which the pin is sampled high.
- R4: cmd_block is high from the edge of acceptance until the edge on which read_ready returns high.
- R5: If the engine was busy at acceptance, ready_busy_n is low for exactly READY_BUSY_T cycles, counted from the edge of acceptance.
- R6: If the engine was idle at acceptance, ready_busy_n stays high for the whole sequence, and the internal ready time is READY_IDLE_T cycles from acceptance.
- R7: read_ready returns high on the later of two edges: the end of the internal ready time, and the edge RECOVER_T cycles after the first high sample of the pin.
- R8: A low sample of the pin during recovery restarts the sequence at once, without a new pulse qualification. The ready timer reloads for the original case, out_hiz returns, and recovery restarts from the next release.
- R9: Outside a reset sequence, ready_busy_n is the inverse of engine_busy, delayed by one register.
- R10: While por_n is low and after it releases, read_ready and ready_busy_n are high and abort_req, out_hiz and cmd_block are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset of the block, active low |
| reset_pin_n | input | 1 | Device hardware reset pin, active low |
| engine_busy | input | 1 | High while the program/erase engine runs |
| abort_req | output | 1 | One-cycle request to the engine to stop |
| out_hiz | output | 1 | Float the data output drivers |
| cmd_block | output | 1 | Ignore all read and write commands |
| read_ready | output | 1 | Array reads are allowed |
| ready_busy_n | output | 1 | Ready/busy pin, low means busy |

## Verification
The bench sends a low run one cycle short of the minimum twice, separated by a single high sample. A qualifier that failed to restart its count would accept this as a reset. A reset during a busy engine checks that ready_busy_n drops for exactly the long time and that read_ready waits for it even though recovery has already finished; a design that used only the recovery time would open reads early. A reset during an idle engine checks that ready_busy_n never drops and that the recovery time, not the short ready time, decides when reads reopen. A re-assertion in the middle of recovery checks that the sequence restarts; a design that ignored it would raise read_ready about ten cycles too soon.

// File: rtl/frs_pkg.sv
package frs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HELD    = 2'd1,
        ST_RECOVER = 2'd2
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       was_busy;
        logic       abort;
        logic       out_hiz;
        logic       cmd_block;
        logic       read_ready;
        logic       rb_n;
    } seq_regs_t;

endpackage

// File: rtl/frs_pulse_qual.sv
module frs_pulse_qual #(
    parameter int PULSE_MIN = 63
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_n,
    input  logic arm,
    output logic qualify
);
    localparam int CW = (PULSE_MIN > 1) ? $clog2(PULSE_MIN + 1) : 1;
    localparam logic [CW-1:0] LAST = CW'(PULSE_MIN - 1);

    logic [CW-1:0] run_d, run_q;

    always_comb begin
        qualify = arm && !pin_n && (run_q == LAST);
        if (arm && !pin_n && !qualify) begin
            run_d = run_q + 1'b1;
        end else begin
            run_d = '0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

endmodule

// File: rtl/frs_down_timer.sv
module frs_down_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire_next
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = '0;
        end
        expire_next = (cnt_d == '0);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq #(
    parameter int PULSE_MIN    = 63,
    parameter int READY_BUSY_T = 2500,
    parameter int READY_IDLE_T = 63,
    parameter int RECOVER_T    = 7
) (
    input  logic clk,
    input  logic por_n,
    input  logic reset_pin_n,
    input  logic engine_busy,
    output logic abort_req,
    output logic out_hiz,
    output logic cmd_block,
    output logic read_ready,
    output logic ready_busy_n
);
    import frs_pkg::*;

    localparam int RDY_MAX = (READY_BUSY_T > READY_IDLE_T) ? READY_BUSY_T : READY_IDLE_T;
    localparam int ALL_MAX = (RDY_MAX > RECOVER_T) ? RDY_MAX : RECOVER_T;
    localparam int TW      = $clog2(ALL_MAX + 1);
    localparam int N_TMR   = 2;
    localparam int T_RDY   = 0;
    localparam int T_REC   = 1;

    seq_regs_t r_d, r_q;
    logic      qualify;
    logic      busy_sel;
    logic      tmr_load [N_TMR];
    logic [TW-1:0] tmr_val [N_TMR];
    logic      tmr_exp  [N_TMR];

    frs_pulse_qual #(.PULSE_MIN(PULSE_MIN)) u_qual (
        .clk     (clk),
        .por_n   (por_n),
        .pin_n   (reset_pin_n),
        .arm     (r_q.state == ST_IDLE),
        .qualify (qualify)
    );

    generate
        for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
            frs_down_timer #(.W(TW)) u_tmr (
                .clk         (clk),
                .por_n       (por_n),
                .load        (tmr_load[g]),
                .load_val    (tmr_val[g]),
                .expire_next (tmr_exp[g])
            );
        end
    endgenerate

    // Timer load controls
    always_comb begin
        busy_sel = qualify ? engine_busy : r_q.was_busy;
        tmr_load[T_RDY] = qualify || ((r_q.state == ST_RECOVER) && !reset_pin_n);
        tmr_val[T_RDY]  = busy_sel ? TW'(READY_BUSY_T) : TW'(READY_IDLE_T);
        tmr_load[T_REC] = (r_q.state == ST_HELD) && reset_pin_n;
        tmr_val[T_REC]  = TW'(RECOVER_T);
    end

    // Next-state logic
    always_comb begin
        r_d       = r_q;
        r_d.abort = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (qualify) begin
                    r_d.state    = ST_HELD;
                    r_d.was_busy = engine_busy;
                    r_d.abort    = engine_busy;
                end
            end
            ST_HELD: begin
                if (reset_pin_n) begin
                    r_d.state = ST_RECOVER;
                end
            end
            ST_RECOVER: begin
                if (!reset_pin_n) begin
                    r_d.state = ST_HELD;
                end else if (tmr_exp[T_RDY] && tmr_exp[T_REC]) begin
                    r_d.state    = ST_IDLE;
                    r_d.was_busy = 1'b0;
                end
            end
            default: begin
                r_d.state    = ST_IDLE;
                r_d.was_busy = 1'b0;
            end
        endcase
        r_d.out_hiz    = (r_d.state == ST_HELD);
        r_d.cmd_block  = (r_d.state != ST_IDLE);
        r_d.read_ready = (r_d.state == ST_IDLE);
        if (r_d.state == ST_IDLE) begin
            r_d.rb_n = !engine_busy;
        end else begin
            r_d.rb_n = !(r_d.was_busy && !tmr_exp[T_RDY]);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            r_q <= '{state: ST_IDLE, was_busy: 1'b0, abort: 1'b0, out_hiz: 1'b0,
                     cmd_block: 1'b0, read_ready: 1'b1, rb_n: 1'b1};
        end else begin
            r_q <= r_d;
        end
    end

    assign abort_req    = r_q.abort;
    assign out_hiz      = r_q.out_hiz;
    assign cmd_block    = r_q.cmd_block;
    assign read_ready   = r_q.read_ready;
    assign ready_busy_n = r_q.rb_n;

endmodule

// File: rtl/frs_chk.sv
module frs_chk #(
    parameter int PULSE_MIN = 63
) (
    input logic clk,
    input logic por_n,
    input logic reset_pin_n,
    input logic abort_req,
    input logic out_hiz,
    input logic cmd_block,
    input logic read_ready
);
    localparam int CW = $clog2(PULSE_MIN + 1);
    logic [CW-1:0] low_run_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            low_run_q <= '0;
        end else if (reset_pin_n) begin
            low_run_q <= '0;
        end else if (low_run_q != CW'(PULSE_MIN)) begin
            low_run_q <= low_run_q + 1'b1;
        end
    end

    // R1
    min_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(cmd_block) |-> (low_run_q == CW'(PULSE_MIN)));

    // R2
    abort_single_chk: assert property (@(posedge clk) disable iff (!por_n)
        abort_req |=> !abort_req);

    // R2
    abort_with_hiz_chk: assert property (@(posedge clk) disable iff (!por_n)
        abort_req |-> out_hiz);

    // R3
    hiz_pin_low_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(out_hiz) |-> !$past(reset_pin_n));

    // R4
    hiz_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!por_n)
        out_hiz |-> cmd_block);

    // R7
    ready_after_release_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(read_ready) |-> $past(reset_pin_n));

endmodule

bind flash_rst_seq frs_chk #(.PULSE_MIN(PULSE_MIN)) u_frs_chk (
    .clk         (clk),
    .por_n       (por_n),
    .reset_pin_n (reset_pin_n),
    .abort_req   (abort_req),
    .out_hiz     (out_hiz),
    .cmd_block   (cmd_block),
    .read_ready  (read_ready)
);

// File: tb/flash_rst_seq_tb.sv
module flash_rst_seq_tb;
    localparam int PMIN = 4;
    localparam int TBSY = 20;
    localparam int TIDL = 6;
    localparam int TREC = 10;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic pin_n = 1'b1;
    logic busy = 1'b0;
    logic abort_req, out_hiz, cmd_block, read_ready, ready_busy_n;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    flash_rst_seq #(.PULSE_MIN(PMIN), .READY_BUSY_T(TBSY),
                    .READY_IDLE_T(TIDL), .RECOVER_T(TREC)) u_dut (
        .clk(clk), .por_n(por_n), .reset_pin_n(pin_n), .engine_busy(busy),
        .abort_req(abort_req), .out_hiz(out_hiz), .cmd_block(cmd_block),
        .read_ready(read_ready), .ready_busy_n(ready_busy_n));

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(string req, string what, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_idle_outs(string req);
        chk(req, "abort_req", abort_req, 1'b0);
        chk(req, "out_hiz", out_hiz, 1'b0);
        chk(req, "cmd_block", cmd_block, 1'b0);
        chk(req, "read_ready", read_ready, 1'b1);
    endtask

    task automatic t_por();
        por_n = 1'b0;
        tick(3);
        chk_idle_outs("R10");
        chk("R10", "ready_busy_n", ready_busy_n, 1'b1);
        por_n = 1'b1;
        tick();
        chk_idle_outs("R10");
        chk("R10", "ready_busy_n", ready_busy_n, 1'b1);
    endtask

    task automatic t_short();
        busy = 1'b1;
        tick();
        chk("R9", "ready_busy_n follows busy", ready_busy_n, 1'b0);
        pin_n = 1'b0;
        for (int i = 0; i < PMIN - 1; i++) begin
            tick();
            chk_idle_outs("R1");
        end
        pin_n = 1'b1;
        tick();
        pin_n = 1'b0;
        for (int i = 0; i < PMIN - 1; i++) begin
            tick();
            chk_idle_outs("R1");
        end
        pin_n = 1'b1;
        tick();
        chk_idle_outs("R1");
        busy = 1'b0;
        tick();
        chk("R9", "ready_busy_n follows idle", ready_busy_n, 1'b1);
    endtask

    task automatic t_idle();
        pin_n = 1'b0;
        tick(3);
        chk("R1", "out_hiz before min", out_hiz, 1'b0);
        tick();
        chk("R3", "out_hiz at accept", out_hiz, 1'b1);
        chk("R4", "cmd_block at accept", cmd_block, 1'b1);
        chk("R2", "no abort when idle", abort_req, 1'b0);
        chk("R6", "rb high at accept", ready_busy_n, 1'b1);
        for (int i = 5; i <= 8; i++) begin
            tick();
            chk("R6", "rb high held", ready_busy_n, 1'b1);
        end
        pin_n = 1'b1;
        tick();
        chk("R3", "out_hiz clears", out_hiz, 1'b0);
        chk("R4", "cmd_block held", cmd_block, 1'b1);
        tick(9);
        chk("R7", "read_ready waits for recovery", read_ready, 1'b0);
        chk("R6", "rb high in recovery", ready_busy_n, 1'b1);
        tick();
        chk("R7", "read_ready after recovery", read_ready, 1'b1);
        chk("R4", "cmd_block released", cmd_block, 1'b0);
    endtask

    task automatic t_busy();
        busy = 1'b1;
        tick();
        pin_n = 1'b0;
        tick(4);
        chk("R2", "abort at accept", abort_req, 1'b1);
        chk("R5", "rb low at accept", ready_busy_n, 1'b0);
        busy = 1'b0;
        tick();
        chk("R2", "abort single cycle", abort_req, 1'b0);
        tick();
        pin_n = 1'b1;
        tick();
        chk("R3", "out_hiz clears", out_hiz, 1'b0);
        tick(10);
        chk("R7", "busy time dominates recovery", read_ready, 1'b0);
        tick(6);
        chk("R5", "rb still low", ready_busy_n, 1'b0);
        chk("R7", "read_ready before ready time", read_ready, 1'b0);
        tick();
        chk("R5", "rb high after busy time", ready_busy_n, 1'b1);
        chk("R7", "read_ready at ready time", read_ready, 1'b1);
    endtask

    task automatic t_reassert();
        pin_n = 1'b0;
        tick(4);
        chk("R3", "out_hiz at accept", out_hiz, 1'b1);
        tick();
        pin_n = 1'b1;
        tick();
        chk("R3", "out_hiz clears", out_hiz, 1'b0);
        tick(6);
        pin_n = 1'b0;
        tick();
        chk("R8", "out_hiz on reassert", out_hiz, 1'b1);
        chk("R8", "no abort on reassert", abort_req, 1'b0);
        tick();
        pin_n = 1'b1;
        tick();
        chk("R8", "out_hiz clears again", out_hiz, 1'b0);
        tick(9);
        chk("R8", "read_ready held after restart", read_ready, 1'b0);
        tick();
        chk("R8", "read_ready after restarted recovery", read_ready, 1'b1);
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        t_por();
        t_short();
        t_idle();
        tick(2);
        t_busy();
        tick(2);
        t_reassert();
        tick(2);
        done = 1'b1;
        finish_up();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_up();
        end
    end

endmodule